// File: doc/BRIEF.md
# Primary-Supply Power-OK Sequencer

This block turns a digital "primary supply is above threshold" flag into a clean, active-high power-OK level. That level can switch on a secondary regulator once the primary rail has settled. Power-OK rises only after the primary flag has stayed high without a break for a programmable number of clock cycles. It drops at the first clock edge at which the primary flag is seen low, and the delay then starts again from zero.

The block also gates the start of the main reset timeout. A downstream reset-timeout counter may run only while power-OK is high and the secondary supply flag is also high. The reset stretch is therefore measured only after the primary rail has settled and the secondary rail is good.

Power-OK is taken from a dedicated flip-flop. The output stage and the analog comparators lie outside this block.

Top module: `pok_sequencer`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `pwr_ok` and `rst_tmr_en` are 0.
- R2: Whenever `pri_good` is sampled 0 at a rising clock edge, `pwr_ok` is 0 after that edge.
- R3: `pwr_ok` becomes 1 at the rising edge at which `pri_good` has been sampled 1 on `OK_DELAY` consecutive edges, and not one edge earlier.
- R4: After `pwr_ok` has been 1, a single low sample of `pri_good` clears it. Once the flag recovers, a full new run of `OK_DELAY` good samples is needed before `pwr_ok` rises again.
- R5: A low sample of `pri_good` part way through the delay restarts the count from zero. Good samples taken before the drop count for nothing.
- R6: `pwr_ok` does not depend on `sec_good`. Toggling `sec_good` leaves `pwr_ok` unchanged at every edge.
- R7: `rst_tmr_en` is 1 exactly when `pwr_ok` is 1 and `sec_good` is 1. It follows `sec_good` in the same cycle and is 0 whenever `pwr_ok` is 0.
- R8: Once high, `pwr_ok` stays high for as long as `pri_good` stays 1, however long that is. The delay counter saturates and does not wrap.
- R9: With `OK_DELAY` = 1, `pwr_ok` rises at the first edge at which `pri_good` is sampled 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pri_good | input | 1 | Primary supply above its threshold |
| sec_good | input | 1 | Secondary supply above its threshold |
| pwr_ok | output | 1 | Registered power-OK for the primary supply |
| rst_tmr_en | output | 1 | Permission for the reset-timeout counter to run |

## Verification
The bench builds two copies of the block side by side. One uses `OK_DELAY` = 6, so the full delay, a restart in mid-count and a long saturated hold all fit in a few dozen cycles. The other uses `OK_DELAY` = 1, which reaches the corner where the count terminates on its first good sample. Both copies are driven with the same supply flags, including runs that fall just short of the delay and single-cycle drops. Each copy is compared on every clock against a behavioural count of consecutive good samples.

// File: rtl/pok_pkg.sv
package pok_pkg;

    typedef enum logic [1:0] {
        SEQ_DOWN  = 2'd0,
        SEQ_DELAY = 2'd1,
        SEQ_UP    = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic clear;
        logic at_end;
    } cnt_ctl_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/pok_delay_counter.sv
module pok_delay_counter
    import pok_pkg::*;
#(
    parameter int LIMIT = 11_250_000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    output cnt_ctl_t ctl
);
    localparam int CW = cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ctl.clear  = clear;
        ctl.at_end = (cnt_q == LAST);
    end

endmodule

// File: rtl/pok_state_ctrl.sv
module pok_state_ctrl
    import pok_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pri_good,
    input  cnt_ctl_t ctl,
    output logic     ok_q
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!pri_good) begin
            state_d = SEQ_DOWN;
        end else if (state_q == SEQ_UP || (ctl.at_end && !ctl.clear)) begin
            state_d = SEQ_UP;
        end else begin
            state_d = SEQ_DELAY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_DOWN;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ok_q    <= (state_d == SEQ_UP);
        end
    end

endmodule

// File: rtl/pok_sequencer.sv
module pok_sequencer
    import pok_pkg::*;
#(
    parameter int OK_DELAY = 11_250_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pri_good,
    input  logic sec_good,
    output logic pwr_ok,
    output logic rst_tmr_en
);
    cnt_ctl_t ctl;
    logic     ok_q;

    pok_delay_counter #(.LIMIT(OK_DELAY)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (!pri_good),
        .ctl   (ctl)
    );

    pok_state_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .pri_good (pri_good),
        .ctl      (ctl),
        .ok_q     (ok_q)
    );

    assign pwr_ok     = ok_q;
    assign rst_tmr_en = ok_q & sec_good;

endmodule

// File: rtl/pok_sequencer_chk.sv
module pok_sequencer_chk #(
    parameter int OK_DELAY = 11_250_000
) (
    input logic clk,
    input logic rst,
    input logic pri_good,
    input logic sec_good,
    input logic pwr_ok,
    input logic rst_tmr_en
);
    localparam int RW = $clog2(OK_DELAY + 1) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !pri_good) begin
            run_q <= '0;
        end else if (run_q < RW'(OK_DELAY)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_low_after_bad_R2: assert property (@(posedge clk) disable iff (rst)
        !pri_good |=> !pwr_ok);

    assert_rise_after_full_run_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_ok) |-> (run_q == RW'(OK_DELAY)));

    assert_hold_while_good_R8: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && pri_good) |=> pwr_ok);

    assert_tmr_needs_settled_R7: assert property (@(posedge clk) disable iff (rst)
        rst_tmr_en |-> (run_q == RW'(OK_DELAY)) && sec_good);

endmodule

bind pok_sequencer pok_sequencer_chk #(.OK_DELAY(OK_DELAY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pri_good   (pri_good),
    .sec_good   (sec_good),
    .pwr_ok     (pwr_ok),
    .rst_tmr_en (rst_tmr_en)
);

// File: tb/tb_pok_sequencer.sv
`timescale 1ns/1ps
module tb_pok_sequencer;
    localparam int D_MAIN = 6;
    localparam int D_MIN  = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pri_good = 1'b0;
    logic sec_good = 1'b0;
    logic ok6, en6, ok1, en1;

    int    errors = 0;
    int    checks = 0;
    int    run    = 0;
    string req    = "R1";
    bit    done   = 1'b0;

    always #2.5 clk = ~clk;

    pok_sequencer #(.OK_DELAY(D_MAIN)) dut (
        .clk(clk), .rst(rst), .pri_good(pri_good), .sec_good(sec_good),
        .pwr_ok(ok6), .rst_tmr_en(en6));

    pok_sequencer #(.OK_DELAY(D_MIN)) dut_min (
        .clk(clk), .rst(rst), .pri_good(pri_good), .sec_good(sec_good),
        .pwr_ok(ok1), .rst_tmr_en(en1));

    // Reference: length of the current run of good primary samples
    always @(posedge clk) begin
        if (rst || !pri_good) run <= 0;
        else if (run < 100000) run <= run + 1;
    end

    task automatic check(input string r, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b (t=%0t)", r, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the edge
    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                check("R1", "pwr_ok in reset", ok6, 1'b0);
                check("R1", "rst_tmr_en in reset", en6, 1'b0);
            end else begin
                check(req, "pwr_ok D=6", ok6, run >= D_MAIN);
                check(req, "rst_tmr_en D=6", en6, (run >= D_MAIN) && sec_good);
                check((req == "R3") ? "R9" : req, "pwr_ok D=1", ok1, run >= D_MIN);
                check(req, "rst_tmr_en D=1", en1, (run >= D_MIN) && sec_good);
            end
        end
    end

    task automatic drive(input logic p, input logic s, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            pri_good = p;
            sec_good = s;
        end
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        req = "R1";
        drive(1'b1, 1'b1, 4);          // inputs high during reset must not matter
        @(posedge clk); #1; rst = 1'b0; pri_good = 1'b0;
        drive(1'b0, 1'b1, 2);
        req = "R3";                     // full delay, first good edge for D=1 (R9)
        drive(1'b1, 1'b1, 10);
        req = "R8";                     // long hold, counter saturates
        drive(1'b1, 1'b1, 40);
        req = "R7";                     // sec_good gates the enable only
        drive(1'b1, 1'b0, 3);
        drive(1'b1, 1'b1, 2);
        req = "R4";                     // single drop clears power-OK
        drive(1'b0, 1'b1, 1);
        drive(1'b1, 1'b1, 9);
        req = "R5";                     // drop in mid-count restarts
        drive(1'b0, 1'b1, 1);
        drive(1'b1, 1'b1, 5);
        drive(1'b0, 1'b1, 1);
        drive(1'b1, 1'b1, 9);
        req = "R6";                     // secondary toggling during delay
        drive(1'b0, 1'b0, 2);
        for (int i = 0; i < 14; i++) drive(1'b1, i[0], 1);
        req = "R2";                     // primary held low
        drive(1'b0, 1'b1, 6);
        req = "R5";                     // pseudo-random mix
        for (int i = 0; i < 200; i++) drive(($urandom % 8) != 0, $urandom % 2, 1);
        drive(1'b0, 1'b0, 2);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule